// File: doc/BRIEF.md
# Character Display Host Register Pair

This block is the host-facing side of a character display controller. The host reaches two byte-wide registers through a register-select input. Low selects the instruction register and high selects the data register. An instruction write can set an address in one of two internal memories: an 80-byte display memory or a 64-byte glyph-pattern memory. Setting an address loads an address pointer and picks the memory that later data accesses use.

Data reads are served ahead of time. Setting an address copies the addressed byte into the data register in the next internal cycle. Each host data read returns the byte already held there. The block then advances the pointer and refills the register from the new location in the background. Host data writes park the byte in the data register and commit it to the selected memory one internal cycle later. A busy output marks the single internal cycle after each such operation, and host accesses that arrive during that cycle are dropped.

Top module: `disp_regpair`

## Requirements
- R1: After synchronous reset, `busy`, `host_rvalid` and `host_rdata` are 0, every byte of both memories is 0, and the pointer selects display memory at address 0.
- R2: An instruction write (`host_rs`=0, `host_rw`=0) with bit 7 set selects display memory and loads bits 6..0 as the address, or address 0 when that value is 80 or more. In the next cycle the byte at that address is copied into the data register.
- R3: An instruction write with bits 7..6 equal to 01 selects glyph memory and loads bits 5..0 as the address, with the same prefetch. The two memories hold separate contents.
- R4: An instruction write with bits 7..6 equal to 00 does not raise `busy`, does not move the pointer and does not change the data register.
- R5: A data read (`host_rs`=1, `host_rw`=1) accepted at a clock edge drives the data register's byte onto `host_rdata` with `host_rvalid` high for exactly the following cycle.
- R6: After each accepted data read the pointer advances by one and the data register is refilled from the new location, so successive reads return consecutive bytes.
- R7: A data write (`host_rs`=1, `host_rw`=0) stores the byte at the pointer in the selected memory, then advances the pointer by one.
- R8: The pointer wraps from 79 to 0 in display memory and from 63 to 0 in glyph memory.
- R9: `busy` is high for exactly one cycle after every address set, data read and data write. Any access presented during that cycle is ignored.
- R10: The instruction register cannot be read. An access with `host_rs`=0, `host_rw`=1 produces no `host_rvalid`, no busy cycle and no pointer movement.
- R11: After a data write, the data register keeps the written byte. A data read that follows without an address set returns that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_en | input | 1 | Host access strobe, one cycle per access |
| host_rs | input | 1 | Register select: 0 instruction, 1 data |
| host_rw | input | 1 | Direction: 1 read, 0 write |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte returned by a data read |
| host_rvalid | output | 1 | High for one cycle when `host_rdata` carries a read result |
| busy | output | 1 | Internal prefetch or store cycle in progress |

## Verification
The bench runs the pointer across the top of each memory. A design that wraps at the wrong bound, or wraps both memories at the same bound, returns the wrong bytes on readback. It sends back-to-back strobes so that the second one lands in the busy cycle. A design that accepts that strobe overwrites a stored byte or emits an extra read result.

Reading straight after a write separates the held write byte from a fresh fetch. Out-of-range display addresses, plain instruction codes and attempted instruction-register reads are each followed by a data read. A design that moves the pointer or drops the prefetch in those cases returns a byte from the wrong location.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam int DATA_W       = 8;
    localparam int ADDR_W       = 7;
    localparam int DD_DEPTH_DEF = 80;
    localparam int CG_DEPTH_DEF = 64;

    typedef enum logic {
        SEL_DD = 1'b0,
        SEL_CG = 1'b1
    } ram_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ASET  = 2'd1,
        ST_FETCH = 2'd2,
        ST_STORE = 2'd3
    } ctl_state_e;

    typedef struct packed {
        ram_sel_e            sel;
        logic [ADDR_W-1:0]   addr;
    } ram_ptr_t;

    function automatic logic is_addr_set(input logic [DATA_W-1:0] code);
        return code[7] | (code[7:6] == 2'b01);
    endfunction

    function automatic ram_ptr_t decode_set(input logic [DATA_W-1:0] code,
                                            input int dd_depth);
        ram_ptr_t p;
        if (code[7]) begin
            p.sel  = SEL_DD;
            p.addr = (int'(code[6:0]) >= dd_depth) ? '0 : code[6:0];
        end else begin
            p.sel  = SEL_CG;
            p.addr = {1'b0, code[5:0]};
        end
        return p;
    endfunction

    function automatic ram_ptr_t step_ptr(input ram_ptr_t p,
                                          input int dd_depth,
                                          input int cg_depth);
        ram_ptr_t n;
        int       lim;
        lim   = (p.sel == SEL_DD) ? dd_depth : cg_depth;
        n.sel = p.sel;
        if (int'(p.addr) >= lim - 1) n.addr = '0;
        else                         n.addr = p.addr + 1'b1;
        return n;
    endfunction

endpackage

// File: rtl/disp_ram.sv
module disp_ram #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R8
    ram_waddr_range_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> (int'(waddr) < DEPTH));

endmodule

// File: rtl/disp_addr_ctr.sv
module disp_addr_ctr
    import disp_pkg::*;
#(
    parameter int DD_DEPTH = DD_DEPTH_DEF,
    parameter int CG_DEPTH = CG_DEPTH_DEF
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  ram_ptr_t load_ptr,
    input  logic     step,
    output ram_ptr_t ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr.sel  <= SEL_DD;
            ptr.addr <= '0;
        end else if (load) begin
            ptr <= load_ptr;
        end else if (step) begin
            ptr <= step_ptr(ptr, DD_DEPTH, CG_DEPTH);
        end
    end

    // R8
    addr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr.sel == SEL_DD) ? (int'(ptr.addr) < DD_DEPTH)
                            : (int'(ptr.addr) < CG_DEPTH));

    // R6
    step_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (ptr.addr != $past(ptr.addr)));

endmodule

// File: rtl/disp_host_ctrl.sv
module disp_host_ctrl
    import disp_pkg::*;
#(
    parameter int DD_DEPTH = DD_DEPTH_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_en,
    input  logic              host_rs,
    input  logic              host_rw,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] fetch_data,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              busy,
    output logic              ptr_load,
    output ram_ptr_t          load_ptr,
    output logic              ptr_step,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata
);

    ctl_state_e        state;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] dr_q;
    logic              accept;
    logic              acc_rd;
    logic              acc_wr;
    logic              acc_ins;

    assign busy    = (state != ST_IDLE);
    assign accept  = host_en && !busy;
    assign acc_rd  = accept &&  host_rs &&  host_rw;
    assign acc_wr  = accept &&  host_rs && !host_rw;
    assign acc_ins = accept && !host_rs && !host_rw;

    always_comb begin
        ptr_load  = (state == ST_ASET);
        load_ptr  = decode_set(ir_q, DD_DEPTH);
        ptr_step  = (state == ST_STORE) || acc_rd;
        ram_we    = (state == ST_STORE);
        ram_wdata = dr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            ir_q        <= '0;
            dr_q        <= '0;
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (acc_ins) begin
                        ir_q <= host_wdata;
                        if (is_addr_set(host_wdata)) state <= ST_ASET;
                    end else if (acc_rd) begin
                        host_rdata  <= dr_q;
                        host_rvalid <= 1'b1;
                        state       <= ST_FETCH;
                    end else if (acc_wr) begin
                        dr_q  <= host_wdata;
                        state <= ST_STORE;
                    end
                end
                ST_ASET, ST_FETCH: begin
                    dr_q  <= fetch_data;
                    state <= ST_IDLE;
                end
                ST_STORE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9
    busy_single_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && host_en) |=> !host_rvalid);

    // R5
    rvalid_cause_chk: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |-> $past(host_en && host_rs && host_rw && !busy));

    // R10
    ir_read_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (host_en && !busy && !host_rs && host_rw) |=> (!busy && !host_rvalid));

    // R4
    plain_code_chk: assert property (@(posedge clk) disable iff (rst)
        (host_en && !busy && !host_rs && !host_rw && (host_wdata[7:6] == 2'b00))
        |=> !busy);

    // R7
    store_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> $past(host_en && host_rs && !host_rw && !busy));

endmodule

// File: rtl/disp_regpair.sv
module disp_regpair
    import disp_pkg::*;
#(
    parameter int DD_DEPTH = DD_DEPTH_DEF,
    parameter int CG_DEPTH = CG_DEPTH_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_en,
    input  logic              host_rs,
    input  logic              host_rw,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              busy
);

    localparam int NUM_BANKS = 2;

    ram_ptr_t          cur_ptr;
    ram_ptr_t          load_ptr;
    ram_ptr_t          fetch_ptr;
    logic              ptr_load;
    logic              ptr_step;
    logic              ram_we;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] fetch_data;
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];

    disp_host_ctrl #(.DD_DEPTH(DD_DEPTH)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .host_en     (host_en),
        .host_rs     (host_rs),
        .host_rw     (host_rw),
        .host_wdata  (host_wdata),
        .fetch_data  (fetch_data),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .busy        (busy),
        .ptr_load    (ptr_load),
        .load_ptr    (load_ptr),
        .ptr_step    (ptr_step),
        .ram_we      (ram_we),
        .ram_wdata   (ram_wdata)
    );

    disp_addr_ctr #(.DD_DEPTH(DD_DEPTH), .CG_DEPTH(CG_DEPTH)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_ptr (load_ptr),
        .step     (ptr_step),
        .ptr      (cur_ptr)
    );

    assign fetch_ptr  = ptr_load ? load_ptr : cur_ptr;
    assign fetch_data = bank_rd[fetch_ptr.sel];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam int       DEPTH = (g == 0) ? DD_DEPTH : CG_DEPTH;
        localparam int       AW    = $clog2(DEPTH);
        localparam ram_sel_e SEL   = (g == 0) ? SEL_DD : SEL_CG;
        logic bank_we;
        assign bank_we = ram_we && (cur_ptr.sel == SEL);

        disp_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
            .clk   (clk),
            .rst   (rst),
            .we    (bank_we),
            .waddr (cur_ptr.addr[AW-1:0]),
            .wdata (ram_wdata),
            .raddr (fetch_ptr.addr[AW-1:0]),
            .rdata (bank_rd[g])
        );
    end

endmodule

// File: tb/test_disp_regpair.sv
module test_disp_regpair;

    localparam int CLK_PERIOD = 10;
    localparam int DD_N = 80;
    localparam int CG_N = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_en = 1'b0;
    logic       host_rs = 1'b0;
    logic       host_rw = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_rvalid;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] dd_m [DD_N];
    logic [7:0] cg_m [CG_N];
    int         m_addr = 0;
    bit         m_cg = 1'b0;
    logic [7:0] m_dr = '0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    disp_regpair i_disp_regpair (
        .clk         (clk),
        .rst         (rst),
        .host_en     (host_en),
        .host_rs     (host_rs),
        .host_rw     (host_rw),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .busy        (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected read bytes as read results appear
    always @(negedge clk) begin
        if (!rst && host_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5/R9/R10 unexpected read result actual=%0h expected=none",
                         host_rdata);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (host_rdata !== e) begin
                    errors++;
                    $display("FAIL %s read actual=%0h expected=%0h", t, host_rdata, e);
                end
            end
        end
    end

    function automatic logic [7:0] m_mem(input bit cg, input int a);
        return cg ? cg_m[a] : dd_m[a];
    endfunction

    function automatic void m_step();
        int lim;
        lim = m_cg ? CG_N : DD_N;
        m_addr = (m_addr + 1) % lim;
    endfunction

    task automatic strobe(input logic rs, input logic rw, input logic [7:0] d);
        @(negedge clk);
        host_en = 1'b1; host_rs = rs; host_rw = rw; host_wdata = d;
        @(negedge clk);
        host_en = 1'b0;
    endtask

    task automatic do_set(input logic [7:0] code);
        if (code[7]) begin
            m_cg = 1'b0;
            m_addr = (int'(code[6:0]) >= DD_N) ? 0 : int'(code[6:0]);
            m_dr = m_mem(m_cg, m_addr);
        end else if (code[6]) begin
            m_cg = 1'b1;
            m_addr = int'(code[5:0]);
            m_dr = m_mem(m_cg, m_addr);
        end
        strobe(1'b0, 1'b0, code);
    endtask

    task automatic do_read(input string tag);
        exp_q.push_back(m_dr);
        tag_q.push_back(tag);
        m_step();
        m_dr = m_mem(m_cg, m_addr);
        strobe(1'b1, 1'b1, 8'h00);
    endtask

    task automatic do_write(input logic [7:0] d);
        m_dr = d;
        if (m_cg) cg_m[m_addr] = d; else dd_m[m_addr] = d;
        m_step();
        strobe(1'b1, 1'b0, d);
    endtask

    // Two strobes on consecutive edges; the second falls in the busy cycle
    task automatic pair(input logic rw, input logic [7:0] d0, input logic [7:0] d1);
        @(negedge clk);
        host_en = 1'b1; host_rs = 1'b1; host_rw = rw; host_wdata = d0;
        @(negedge clk);
        checks++;
        if (busy !== 1'b1) begin
            errors++;
            $display("FAIL R9 busy after access actual=%0b expected=1", busy);
        end
        host_wdata = d1;
        @(negedge clk);
        host_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < DD_N; i++) dd_m[i] = '0;
        for (int i = 0; i < CG_N; i++) cg_m[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {7'd0, busy}, 8'h00);
        chk("R1 rvalid", {7'd0, host_rvalid}, 8'h00);
        chk("R1 rdata", host_rdata, 8'h00);

        // R1 pointer at display 0 and zeroed memory: write then read back
        do_write(8'h9C);
        do_set(8'h80);
        do_read("R1");
        do_read("R1");

        // R2, R7, R6: write a run and read it back
        do_set(8'h8A);
        do_write(8'hA1); do_write(8'hB2); do_write(8'hC3);
        do_set(8'h8A);
        do_read("R6"); do_read("R6"); do_read("R6"); do_read("R6");

        // R11: read right after write returns the held byte
        do_set(8'h94);
        do_write(8'h5A);
        do_read("R11");
        do_read("R11");

        // R8: display wrap 79 -> 0
        do_set(8'hCF);
        do_write(8'h11); do_write(8'h22);
        do_set(8'hCF);
        do_read("R8"); do_read("R8"); do_read("R8");

        // R3, R8: glyph memory wrap 63 -> 0 and separation from display memory
        do_set(8'h7E);
        do_write(8'h33); do_write(8'h44); do_write(8'h55);
        do_set(8'h7E);
        do_read("R3"); do_read("R3"); do_read("R8"); do_read("R8");
        do_set(8'h80);
        do_read("R3");

        // R2: out-of-range display address loads 0
        do_set(8'hFF);
        do_read("R2");

        // R4: plain instruction code changes nothing
        do_set(8'h8B);
        strobe(1'b0, 1'b0, 8'h05);
        chk("R4 busy", {7'd0, busy}, 8'h00);
        do_read("R4");

        // R10: instruction register read is silent
        do_set(8'h8C);
        strobe(1'b0, 1'b1, 8'h00);
        chk("R10 busy", {7'd0, busy}, 8'h00);
        do_read("R10");

        // R9: write during busy is dropped
        do_set(8'h9E);
        m_dr = 8'h77; dd_m[30] = 8'h77; m_step();
        pair(1'b0, 8'h77, 8'h88);
        do_set(8'h9E);
        do_read("R9"); do_read("R9");

        // R9: read during busy is dropped
        do_set(8'h8A);
        exp_q.push_back(m_dr); tag_q.push_back("R9");
        m_step(); m_dr = m_mem(m_cg, m_addr);
        pair(1'b1, 8'h00, 8'h00);
        do_read("R9");

        repeat (4) @(negedge clk);
        chk("R5 pending reads", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule